// File: doc/BRIEF.md
# Low-Speed Preamble Transmit Sequencer

This block sits on the transmit side of a USB full-speed line driver. When the transceiver-select code picks preamble operation, every packet the link offers is sent behind a full-speed header that hubs use to open their low-speed ports. The header is the full-speed SYNC pattern and the PRE PID. It is followed by a short timed gap in which the bus first carries an actively driven J and is then left to the pull-up. After that gap the link's own bytes are serialised at the low-speed bit rate and closed with a low-speed end-of-packet. All signalling keeps the full-speed edge behaviour; edge-rate control itself lives in the analog driver.

The only timing input is a one-cycle full-speed bit strobe. Low-speed bits are derived from it by dividing by eight, so each low-speed bit lasts exactly eight strobes. Bytes enter through a valid/ready stream with a last flag. The stream is back-pressured for the whole of the header and the gap. The block holds at most one byte ahead of the serialiser. The link keeps `tx_data` and `tx_last` stable while `tx_valid` is high and `tx_ready` is low, and must present each following byte before the byte on the line finishes. When no byte is waiting at a byte boundary, the packet is closed. Between packets the drive-enable stays low, so the bus is free for traffic arriving from the far end.

Top module: `ls_preamble_tx`

## Requirements
- R1: A packet starts only when `xcvr_sel` equals binary 11 and `tx_valid` is high at a bit strobe while the block is idle. With any other select code, `drive_en` and `tx_ready` stay low and the line reads J.
- R2: Line encoding is J = 01, K = 10, SE0 = 00. One strobe after the start, the block drives 16 full-speed bits: 0x80 (SYNC) and then 0x3C (PRE), each LSB first. The bits are NRZI coded from a J level, where a 0 toggles the level and a 1 keeps it.
- R3: Exactly GAP_BITS full-speed bit times (at least four) separate the last PRE bit from the first low-speed SYNC bit. The line reads J for the whole gap. `drive_en` is high for the first GAP_DRIVE of those bit times and low for the rest.
- R4: Each low-speed bit, including the SYNC, the stuffed bits and the end-of-packet symbols, lasts exactly LS_DIV (eight) full-speed bit times.
- R5: The low-speed part is the SYNC byte 0x80 followed by the link's bytes in order, each LSB first. The NRZI coding restarts from the J level.
- R6: After six consecutive 1 bits a 0 is inserted, in the header and in the low-speed part alike. This includes a run that ends on the last payload bit, just before the end-of-packet.
- R7: The low-speed part closes with two low-speed bit times of driven SE0 and one of driven J. After that, `drive_en` falls and stays low, and the line reads J whenever it is low.
- R8: `tx_ready` is low while idle, during the header and during the gap. It rises only after low-speed serialisation has begun. After each accepted byte it drops for at least one cycle. It never rises once the byte flagged `tx_last` has been accepted. Every byte of a packet is taken exactly once.
- R9: After reset, `drive_en` and `tx_ready` are low and the line reads J.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| xcvr_sel | input | 2 | Transceiver-select code; 11 selects preamble operation |
| bit_en | input | 1 | Full-speed bit strobe, one cycle high per bit time |
| tx_data | input | 8 | Transmit byte |
| tx_valid | input | 1 | Transmit byte present |
| tx_last | input | 1 | Marks the final byte of the packet |
| tx_ready | output | 1 | Block accepts the byte this cycle |
| line_state | output | 2 | Bus symbol: J 01, K 10, SE0 00 |
| drive_en | output | 1 | Line driver enabled |

## Verification
The bench builds the block with GAP_BITS = 5, GAP_DRIVE = 2 and LS_DIV = 8. A gap longer than the minimum, with more than one driven bit, makes the boundary between the driven and the released parts of the gap visible at the pins. The strobe comes every third clock, so the bench can tell strobe cycles from the cycles in between. Six payloads of one to three bytes are swept, covering stuffing inside a byte, across the SYNC-to-data boundary, across byte boundaries and right before the end-of-packet. The three non-preamble select codes are also swept.

// File: rtl/ls_pre_pkg.sv
package ls_pre_pkg;

  typedef enum logic [1:0] {
    LINE_SE0 = 2'b00,
    LINE_J   = 2'b01,
    LINE_K   = 2'b10
  } line_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_GAP,
    ST_LSDATA,
    ST_EOP
  } seq_e;

  localparam int BYTE_W      = 8;
  localparam int HDR_LEN     = 16;
  localparam int STUFF_RUN   = 6;
  // SYNC in the low byte, PRE PID in the high byte, shifted out LSB first
  localparam logic [HDR_LEN-1:0] PRE_HEADER = 16'h3C80;
  localparam logic [BYTE_W-1:0]  SYNC_BYTE  = 8'h80;

endpackage

// File: rtl/ls_rate_div.sv
module ls_rate_div #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fs_en,
  input  logic hold_zero,
  output logic ls_tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (hold_zero) begin
      cnt <= '0;
    end else if (fs_en) begin
      cnt <= (cnt == W'(DIV - 1)) ? '0 : cnt + 1'b1;
    end
  end

  assign ls_tick = fs_en && (cnt == '0);
endmodule

// File: rtl/nrzi_stuff_enc.sv
module nrzi_stuff_enc #(
  parameter int RUN = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic park_j,
  input  logic bit_v,
  input  logic bit_in,
  output logic level_j,
  output logic stuff_due
);
  localparam int RW = $clog2(RUN + 1);

  logic [RW-1:0] ones;

  assign stuff_due = (ones == RW'(RUN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_j <= 1'b1;
      ones    <= '0;
    end else if (tick) begin
      if (park_j) begin
        level_j <= 1'b1;
        ones    <= '0;
      end else if (bit_v) begin
        if (stuff_due || !bit_in) begin
          level_j <= ~level_j;
          ones    <= '0;
        end else begin
          ones <= ones + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tx_hold_reg.sv
module tx_hold_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         open_en,
  input  logic         flush,
  input  logic         take,
  input  logic         tx_valid,
  input  logic [W-1:0] tx_data,
  input  logic         tx_last,
  output logic         tx_ready,
  output logic         full,
  output logic [W-1:0] data_q
);
  logic last_seen;

  assign tx_ready = open_en && !full && !last_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full      <= 1'b0;
      last_seen <= 1'b0;
      data_q    <= '0;
    end else if (flush) begin
      full      <= 1'b0;
      last_seen <= 1'b0;
    end else begin
      if (take) full <= 1'b0;
      if (tx_valid && tx_ready) begin
        data_q    <= tx_data;
        full      <= 1'b1;
        last_seen <= tx_last;
      end
    end
  end
endmodule

// File: rtl/ls_preamble_tx.sv
module ls_preamble_tx
  import ls_pre_pkg::*;
#(
  parameter int LS_DIV    = 8,
  parameter int GAP_BITS  = 4,
  parameter int GAP_DRIVE = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        xcvr_sel,
  input  logic              bit_en,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_valid,
  input  logic              tx_last,
  output logic              tx_ready,
  output logic [1:0]        line_state,
  output logic              drive_en
);
  localparam int CNT_TOP = (GAP_BITS > HDR_LEN) ? GAP_BITS : HDR_LEN;
  localparam int CW      = $clog2(CNT_TOP + 1);
  localparam int BCW     = $clog2(BYTE_W);

  seq_e                st;
  logic [CW-1:0]       cnt;
  logic [HDR_LEN-1:0]  hdr_sh;
  logic [BYTE_W-1:0]   byte_sh;
  logic [BCW-1:0]      bcnt;
  logic                done, se0_q, drv_q, ls_live;

  logic in_ls, ls_tick, tick;
  logic level_j, stuff_due;
  logic enc_park, enc_bit_v, enc_bit;
  logic hold_full, take, byte_end;
  logic [BYTE_W-1:0] hold_q;

  assign in_ls    = (st == ST_LSDATA) || (st == ST_EOP);
  assign tick     = in_ls ? ls_tick : bit_en;
  assign byte_end = (bcnt == BCW'(BYTE_W - 1));
  assign take     = tick && (st == ST_LSDATA) && !stuff_due && !done && byte_end && hold_full;

  ls_rate_div #(.DIV(LS_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .fs_en(bit_en), .hold_zero(!in_ls), .ls_tick(ls_tick)
  );

  always_comb begin
    enc_park  = (st == ST_IDLE) || (st == ST_GAP) || ((st == ST_EOP) && (cnt == CW'(2)));
    enc_bit_v = (st == ST_HDR) || ((st == ST_LSDATA) && (stuff_due || !done));
    enc_bit   = (st == ST_HDR) ? hdr_sh[0] : byte_sh[0];
  end

  nrzi_stuff_enc #(.RUN(STUFF_RUN)) u_enc (
    .clk(clk), .rst_n(rst_n), .tick(tick), .park_j(enc_park),
    .bit_v(enc_bit_v), .bit_in(enc_bit), .level_j(level_j), .stuff_due(stuff_due)
  );

  tx_hold_reg #(.W(BYTE_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .open_en((st == ST_LSDATA) && ls_live),
    .flush(st == ST_IDLE), .take(take), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_last(tx_last), .tx_ready(tx_ready), .full(hold_full), .data_q(hold_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      hdr_sh  <= '0;
      byte_sh <= '0;
      bcnt    <= '0;
      done    <= 1'b0;
      se0_q   <= 1'b0;
      drv_q   <= 1'b0;
      ls_live <= 1'b0;
    end else if (tick) begin
      unique case (st)
        ST_IDLE: begin
          drv_q   <= 1'b0;
          se0_q   <= 1'b0;
          ls_live <= 1'b0;
          if (tx_valid && (xcvr_sel == 2'b11)) begin
            st     <= ST_HDR;
            cnt    <= '0;
            hdr_sh <= PRE_HEADER;
          end
        end
        ST_HDR: begin
          drv_q <= 1'b1;
          if (!stuff_due) begin
            hdr_sh <= hdr_sh >> 1;
            if (cnt == CW'(HDR_LEN - 1)) begin
              st  <= ST_GAP;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_GAP: begin
          drv_q <= (cnt < CW'(GAP_DRIVE));
          if (cnt == CW'(GAP_BITS - 1)) begin
            st      <= ST_LSDATA;
            cnt     <= '0;
            byte_sh <= SYNC_BYTE;
            bcnt    <= '0;
            done    <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_LSDATA: begin
          drv_q   <= 1'b1;
          ls_live <= 1'b1;
          if (stuff_due) begin
            // encoder inserts the stuffed zero; the byte source waits
          end else if (done) begin
            se0_q <= 1'b1;
            st    <= ST_EOP;
            cnt   <= CW'(1);
          end else begin
            byte_sh <= byte_sh >> 1;
            bcnt    <= byte_end ? '0 : bcnt + 1'b1;
            if (byte_end) begin
              if (hold_full) byte_sh <= hold_q;
              else           done    <= 1'b1;
            end
          end
        end
        ST_EOP: begin
          if (cnt == CW'(1)) begin
            cnt <= CW'(2);
          end else if (cnt == CW'(2)) begin
            se0_q <= 1'b0;
            cnt   <= CW'(3);
          end else begin
            drv_q   <= 1'b0;
            ls_live <= 1'b0;
            st      <= ST_IDLE;
            cnt     <= '0;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign line_state = se0_q ? LINE_SE0 : (level_j ? LINE_J : LINE_K);
  assign drive_en   = drv_q;
endmodule

// File: rtl/ls_preamble_tx_chk.sv
module ls_preamble_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_en,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [1:0] line_state,
  input logic       drive_en
);
  // R3, R7: a released bus always reads as J
  a_r3_release_is_j: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_en |-> line_state == 2'b01);

  // R7: SE0 only appears while the driver is on
  a_r7_se0_driven: assert property (@(posedge clk) disable iff (!rst_n)
    line_state == 2'b00 |-> drive_en);

  // R4: the line only moves on a full-speed strobe
  a_r4_strobe_only: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(line_state) && $stable(drive_en)));

  // R8: one-deep holding, so an accepted byte closes the window for a cycle
  a_r8_one_deep: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  // R8: bytes are only taken while low-speed serialisation is on the bus
  a_r8_ready_needs_drive: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> drive_en);
endmodule

bind ls_preamble_tx ls_preamble_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .line_state(line_state), .drive_en(drive_en)
);

// File: tb/ls_preamble_tx_test.sv
module ls_preamble_tx_test;
  localparam int GAP  = 5;
  localparam int GDRV = 2;
  localparam int DIV  = 8;
  localparam int NB   = 380;
  localparam logic [1:0] LJ = 2'b01, LK = 2'b10, LSE0 = 2'b00;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] xcvr_sel = 2'b11;
  logic       bit_en = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_valid = 1'b0;
  logic       tx_last = 1'b0;
  logic       tx_ready;
  logic [1:0] line_state;
  logic       drive_en;

  int compared = 0;
  int mismatched = 0;

  logic [1:0] tr_l [NB];
  logic       tr_d [NB];
  logic       tr_r [NB];
  logic [1:0] exp_l [NB];
  logic       exp_d [NB];
  int wp, ones, ls_start, eop_start, consumed;
  logic lvl;

  always #2.5 clk = ~clk;

  ls_preamble_tx #(.LS_DIV(DIV), .GAP_BITS(GAP), .GAP_DRIVE(GDRV)) uut (
    .clk(clk), .rst_n(rst_n), .xcvr_sel(xcvr_sel), .bit_en(bit_en),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last),
    .tx_ready(tx_ready), .line_state(line_state), .drive_en(drive_en)
  );

  function automatic int pkt_len(int p);
    case (p)
      0: return 1; 1: return 1; 2: return 3;
      3: return 1; 4: return 2; default: return 3;
    endcase
  endfunction

  function automatic logic [7:0] pkt_byte(int p, int i);
    case (p)
      0: return 8'hA5;
      1: return 8'hFF;
      2: return (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : 8'h81;
      3: return 8'hFC;
      4: return (i == 0) ? 8'h3F : 8'hFF;
      default: return 8'hFF;
    endcase
  endfunction

  task automatic put(logic [1:0] l, logic d, int rep);
    for (int k = 0; k < rep; k++) begin
      if (wp < NB) begin exp_l[wp] = l; exp_d[wp] = d; end
      wp++;
    end
  endtask

  // NRZI with stuffing, as stated in R2, R5 and R6
  task automatic enc(logic b, int rep);
    if (!b) begin lvl = ~lvl; ones = 0; end else ones++;
    put(lvl ? LJ : LK, 1'b1, rep);
    if (ones == 6) begin
      lvl = ~lvl; ones = 0;
      put(lvl ? LJ : LK, 1'b1, rep);
    end
  endtask

  task automatic build_exp(int p);
    logic [15:0] hdr = 16'h3C80;
    logic [7:0] sy = 8'h80;
    logic [7:0] b;
    for (int i = 0; i < NB; i++) begin exp_l[i] = LJ; exp_d[i] = 1'b0; end
    wp = 1; lvl = 1'b1; ones = 0;
    for (int i = 0; i < 16; i++) enc(hdr[i], 1);
    for (int g = 0; g < GAP; g++) put(LJ, (g < GDRV), 1);
    ls_start = wp; lvl = 1'b1; ones = 0;
    for (int i = 0; i < 8; i++) enc(sy[i], DIV);
    for (int j = 0; j < pkt_len(p); j++) begin
      b = pkt_byte(p, j);
      for (int i = 0; i < 8; i++) enc(b[i], DIV);
    end
    eop_start = wp;
    put(LSE0, 1'b1, 2 * DIV);
    put(LJ, 1'b1, DIV);
  endtask

  // one trace entry per full-speed bit time, sampled after the strobe edge
  task automatic run(int p, int len, int nbits);
    int idx = 0;
    int cyc = 0;
    int nb = 0;
    logic hs;
    tx_valid = 1'b1;
    tx_data  = pkt_byte(p, 0);
    tx_last  = (len == 1);
    while (nb < nbits) begin
      bit_en = (cyc % 3 == 0);
      hs = tx_valid && tx_ready;
      @(posedge clk);
      @(negedge clk);
      if (bit_en) begin
        tr_l[nb] = line_state; tr_d[nb] = drive_en; tr_r[nb] = tx_ready;
        nb++;
      end
      bit_en = 1'b0;
      if (hs) begin
        idx++;
        if (idx < len) begin
          tx_data = pkt_byte(p, idx);
          tx_last = (idx == len - 1);
        end else begin
          tx_valid = 1'b0;
        end
      end
      cyc++;
    end
    tx_valid = 1'b0;
    consumed = idx;
  endtask

  task automatic chk_seg(string tag, int p, int lo, int hi);
    int bad = -1;
    compared++;
    for (int i = lo; i < hi; i++)
      if (bad < 0 && (tr_l[i] !== exp_l[i] || tr_d[i] !== exp_d[i])) bad = i;
    if (bad >= 0) begin
      mismatched++;
      $display("FAIL %s pkt %0d bit %0d: actual line=%b drv=%b expected line=%b drv=%b",
               tag, p, bad, tr_l[bad], tr_d[bad], exp_l[bad], exp_d[bad]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog (R1..R9 unfinished): actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    compared++;
    if (drive_en !== 1'b0 || tx_ready !== 1'b0 || line_state !== LJ) begin
      mismatched++;
      $display("FAIL R9 reset: actual drv=%b rdy=%b line=%b expected drv=0 rdy=0 line=01",
               drive_en, tx_ready, line_state);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R1: no start with the other select codes
    for (int s = 0; s < 3; s++) begin
      int hit = 0;
      xcvr_sel = 2'(s);
      run(0, 1, 40);
      for (int i = 0; i < 40; i++)
        if (tr_d[i] !== 1'b0 || tr_r[i] !== 1'b0 || tr_l[i] !== LJ) hit++;
      compared++;
      if (hit != 0) begin
        mismatched++;
        $display("FAIL R1 sel=%0d: actual %0d active bits expected 0", s, hit);
      end
    end
    xcvr_sel = 2'b11;

    for (int p = 0; p < 6; p++) begin
      int rdy_bad = 0;
      build_exp(p);
      run(p, pkt_len(p), NB);
      chk_seg("R2 header", p, 0, 17);
      chk_seg("R3 gap", p, 17, ls_start);
      chk_seg("R4 R5 R6 low-speed body", p, ls_start, eop_start);
      chk_seg("R7 end of packet and release", p, eop_start, NB);
      for (int i = 0; i < ls_start; i++) if (tr_r[i] !== 1'b0) rdy_bad++;
      compared++;
      if (rdy_bad != 0) begin
        mismatched++;
        $display("FAIL R8 pkt %0d ready before low speed: actual %0d bits expected 0", p, rdy_bad);
      end
      compared++;
      if (consumed != pkt_len(p)) begin
        mismatched++;
        $display("FAIL R8 pkt %0d bytes taken: actual %0d expected %0d", p, consumed, pkt_len(p));
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule